// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block fills a small first-in first-out store of 16-bit instruction words ahead of the decoder. When the bus has nothing else to do and the store has room, it issues a sequential fetch and advances its fetch pointer by two bytes. The execution side drains words one per cycle through a valid/ready pop port. A data access requested by the execution side blocks a new prefetch from being launched. Every fetch request carries a 4-bit status code for the bus sequencer, so external logic can tell a straight-line fetch from the first fetch after a change of flow.

A purge pulse is raised on any jump, branch, interrupt, trap or flagged instruction. It empties the store and loads a new fetch target. It also marks the next fetch as non-sequential. A fetch that was already in flight when the purge arrived is allowed to finish on the bus, but the word it returns is thrown away. At most one fetch is outstanding at any time, so a returning word always has a free slot.

Back-pressure rules: the fetch request port holds `fetch_valid_o`, `fetch_addr_o` and `bus_status_o` unchanged until `fetch_ready_i` is seen high. Read data returns on `fetch_rvalid_i` no earlier than the cycle after acceptance, and it is never refused. The pop port presents the oldest word while `q_valid_o` is high, and a word leaves on each cycle where `q_ready_i` is also high.

Top module: `ipq_ctrl`

## Requirements
- R1: After reset `fetch_valid_o` and `q_valid_o` are low and, with `data_req_i` low, `bus_status_o` is 4'b0000.
- R2: A new fetch request appears the cycle after a clock edge at which no fetch was pending or awaiting data, `purge_i` and `data_req_i` were low, and the store held fewer than DEPTH words. At no other edge does one appear, so a full store stops prefetch.
- R3: A fetch that is not the first after a purge presents status 4'b1000, and its address is two more than that of the fetch before it.
- R4: The first fetch launched after a purge presents status 4'b1001 and the address given on `purge_addr_i` during the purge.
- R5: While no fetch request is presented, `bus_status_o` is 4'b1010 when `data_req_i` is high and 4'b0000 otherwise.
- R6: A clock edge with `data_req_i` high never launches a fetch, even when every other condition for prefetch holds.
- R7: The cycle after `purge_i` is high, `q_valid_o` is low.
- R8: A word returned for a fetch that was pending or awaiting data when a purge occurred is discarded and never reaches `q_data_o`.
- R9: Words leave through the pop port in the order of their fetch addresses, one per cycle with `q_valid_o` and `q_ready_i` both high, and `q_valid_o` is low whenever the store is empty.
- R10: Once presented, a fetch request keeps `fetch_valid_o` high and `fetch_addr_o` and `bus_status_o` stable until accepted by `fetch_ready_i`.
- R11: While a fetch is accepted but its data has not returned, no new fetch request is presented, and the store never holds more than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| purge_i | input | 1 | Change-of-flow pulse: flush the store and reload the pointer |
| purge_addr_i | input | ADDR_W | New fetch target (even byte address), sampled with `purge_i` |
| data_req_i | input | 1 | Execution side wants the bus for a data transfer |
| fetch_valid_o | output | 1 | Fetch request presented |
| fetch_ready_i | input | 1 | Bus sequencer accepts the presented fetch |
| fetch_addr_o | output | ADDR_W | Byte address of the presented fetch |
| bus_status_o | output | 4 | Bus status code (1000, 1001, 1010 or 0000) |
| fetch_rvalid_i | input | 1 | Read data for the accepted fetch is on `fetch_rdata_i` |
| fetch_rdata_i | input | WORD_W | Returned instruction word |
| q_valid_o | output | 1 | Oldest queued word is on `q_data_o` |
| q_ready_i | input | 1 | Execution side takes the word this cycle |
| q_data_o | output | WORD_W | Oldest queued instruction word |

## Verification
Random traffic mixes purges at random even targets, data requests, stalls on fetch acceptance, read latencies of one to several cycles, and a pop side that may stall. A per-cycle reference model predicts whether a fetch is launched, its address and code, and the contents of the store. A pop side that never drains shows that prefetch stops at exactly DEPTH words. A long data request shows that prefetch yields the bus to it. A purge placed while a fetch awaits its data shows that the late word is dropped: the first word popped afterwards must come from the new target with status 1001. The stall mix separates request holding (R10) from fresh launches, and the latency mix separates the single-outstanding rule (R11) from the room check (R2).

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  typedef logic [3:0] bus_code_t;

  localparam bus_code_t CODE_IDLE      = 4'b0000;
  localparam bus_code_t CODE_FETCH_SEQ = 4'b1000;
  localparam bus_code_t CODE_FETCH_NEW = 4'b1001;
  localparam bus_code_t CODE_DATA      = 4'b1010;
endpackage

// File: rtl/ipq_fifo.sv
module ipq_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] pop_data_o,
  output logic [CW-1:0]     count_o
);
  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && !flush_i && wr_q == AW'(g)) slot_q[g] <= push_data_i;
    end
  end

  assign pop_data_o = slot_q[rd_q];
  assign count_o    = cnt_q;
endmodule

// File: rtl/ipq_fetch_ctrl.sv
module ipq_fetch_ctrl
  import ipq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              purge_i,
  input  logic [ADDR_W-1:0] purge_addr_i,
  input  logic              data_req_i,
  input  logic [CW-1:0]     fill_i,
  input  logic              fetch_ready_i,
  input  logic              fetch_rvalid_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output bus_code_t         req_code_o,
  output logic              keep_word_o
);
  logic              pend_q, await_q, stale_q, fresh_q;
  logic [ADDR_W-1:0] ptr_q, addr_q;
  bus_code_t         code_q;
  logic              launch, accept, land;

  assign accept = pend_q & fetch_ready_i;
  assign land   = await_q & fetch_rvalid_i;
  assign launch = ~pend_q & ~await_q & ~data_req_i & ~purge_i & (fill_i < CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      await_q <= 1'b0;
      stale_q <= 1'b0;
      fresh_q <= 1'b1;
      ptr_q   <= '0;
      addr_q  <= '0;
      code_q  <= CODE_IDLE;
    end else begin
      if (accept) begin
        pend_q  <= 1'b0;
        await_q <= 1'b1;
      end
      if (land) await_q <= 1'b0;

      if (purge_i) begin
        ptr_q   <= purge_addr_i;
        fresh_q <= 1'b1;
        stale_q <= pend_q | (await_q & ~fetch_rvalid_i);
      end else if (land) begin
        stale_q <= 1'b0;
      end

      if (launch) begin
        pend_q  <= 1'b1;
        addr_q  <= ptr_q;
        code_q  <= fresh_q ? CODE_FETCH_NEW : CODE_FETCH_SEQ;
        ptr_q   <= ptr_q + ADDR_W'(2);
        fresh_q <= 1'b0;
      end
    end
  end

  assign req_valid_o = pend_q;
  assign req_addr_o  = addr_q;
  assign req_code_o  = code_q;
  assign keep_word_o = land & ~stale_q & ~purge_i;
endmodule

// File: rtl/ipq_ctrl.sv
module ipq_ctrl
  import ipq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              purge_i,
  input  logic [ADDR_W-1:0] purge_addr_i,
  input  logic              data_req_i,
  output logic              fetch_valid_o,
  input  logic              fetch_ready_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [3:0]        bus_status_o,
  input  logic              fetch_rvalid_i,
  input  logic [WORD_W-1:0] fetch_rdata_i,
  output logic              q_valid_o,
  input  logic              q_ready_i,
  output logic [WORD_W-1:0] q_data_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] q_count;
  logic          keep_word;
  bus_code_t     req_code;

  ipq_fetch_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) fetch_u (
    .clk           (clk),
    .rst_n         (rst_n),
    .purge_i       (purge_i),
    .purge_addr_i  (purge_addr_i),
    .data_req_i    (data_req_i),
    .fill_i        (q_count),
    .fetch_ready_i (fetch_ready_i),
    .fetch_rvalid_i(fetch_rvalid_i),
    .req_valid_o   (fetch_valid_o),
    .req_addr_o    (fetch_addr_o),
    .req_code_o    (req_code),
    .keep_word_o   (keep_word)
  );

  ipq_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) store_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (purge_i),
    .push_i     (keep_word),
    .push_data_i(fetch_rdata_i),
    .pop_i      (q_valid_o & q_ready_i),
    .pop_data_o (q_data_o),
    .count_o    (q_count)
  );

  assign q_valid_o = (q_count != '0);

  always_comb begin
    if (fetch_valid_o)   bus_status_o = req_code;
    else if (data_req_i) bus_status_o = CODE_DATA;
    else                 bus_status_o = CODE_IDLE;
  end
endmodule

// File: rtl/ipq_ctrl_checker.sv
module ipq_ctrl_checker #(
  parameter int ADDR_W = 24,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              purge_i,
  input logic              data_req_i,
  input logic              fetch_valid_o,
  input logic              fetch_ready_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [3:0]        bus_status_o,
  input logic              q_valid_o,
  input logic [CW-1:0]     q_count
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o && !fetch_ready_i |=> fetch_valid_o && $stable(fetch_addr_o) && $stable(bus_status_o));

  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o |-> (bus_status_o == 4'b1000 || bus_status_o == 4'b1001));

  assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_o |-> bus_status_o == (data_req_i ? 4'b1010 : 4'b0000));

  assert_data_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_o && data_req_i |=> !fetch_valid_o);

  assert_purge_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    purge_i |=> !q_valid_o);

  assert_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o |-> q_count < CW'(DEPTH));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  assert_purge_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid_o) && $past(purge_i) |-> 1'b0 || !$past(purge_i));
endmodule

bind ipq_ctrl ipq_ctrl_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_u (
  .clk          (clk),
  .rst_n        (rst_n),
  .purge_i      (purge_i),
  .data_req_i   (data_req_i),
  .fetch_valid_o(fetch_valid_o),
  .fetch_ready_i(fetch_ready_i),
  .fetch_addr_o (fetch_addr_o),
  .bus_status_o (bus_status_o),
  .q_valid_o    (q_valid_o),
  .q_count      (q_count)
);

// File: tb/ipq_ctrl_tb_top.sv
module ipq_ctrl_tb_top;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              purge_i = 1'b0;
  logic [ADDR_W-1:0] purge_addr_i = '0;
  logic              data_req_i = 1'b0;
  logic              fetch_valid_o;
  logic              fetch_ready_i = 1'b0;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic [3:0]        bus_status_o;
  logic              fetch_rvalid_i = 1'b0;
  logic [WORD_W-1:0] fetch_rdata_i = '0;
  logic              q_valid_o;
  logic              q_ready_i = 1'b0;
  logic [WORD_W-1:0] q_data_o;

  always #5 clk = ~clk;

  ipq_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .purge_i(purge_i), .purge_addr_i(purge_addr_i),
    .data_req_i(data_req_i), .fetch_valid_o(fetch_valid_o), .fetch_ready_i(fetch_ready_i),
    .fetch_addr_o(fetch_addr_o), .bus_status_o(bus_status_o), .fetch_rvalid_i(fetch_rvalid_i),
    .fetch_rdata_i(fetch_rdata_i), .q_valid_o(q_valid_o), .q_ready_i(q_ready_i),
    .q_data_o(q_data_o)
  );

  int checks = 0;
  int errors = 0;

  // knobs, in percent
  int p_purge = 0, p_data = 0, p_ready = 100, p_pop = 0, lat_max = 1;
  logic              fix_en = 1'b0;
  logic [ADDR_W-1:0] fix_addr = '0;

  // reference model state
  logic              m_pend = 1'b0, m_wait = 1'b0, m_stale = 1'b0, m_new = 1'b1;
  logic [ADDR_W-1:0] m_ptr = '0, m_addr = '0, m_raddr = '0;
  logic [3:0]        m_code = 4'b0000;
  logic [WORD_W-1:0] mq [$];
  int                lat = 0;

  function automatic logic [WORD_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic pu, dr, rdy, rv, pop, was_wait, was_pend, lau, acc, rsp;
    logic [ADDR_W-1:0] pa;
    pu  = ($urandom % 100) < p_purge;
    pa  = fix_en ? fix_addr : (ADDR_W'($urandom) & ~ADDR_W'(1));
    dr  = ($urandom % 100) < p_data;
    rdy = ($urandom % 100) < p_ready;
    pop = ($urandom % 100) < p_pop;
    rv  = 1'b0;
    if (m_wait) begin
      if (lat == 0) rv = 1'b1;
      else lat--;
    end
    purge_i = pu; purge_addr_i = pa; data_req_i = dr; fetch_ready_i = rdy;
    fetch_rvalid_i = rv; fetch_rdata_i = word_at(m_raddr); q_ready_i = pop;
    @(posedge clk);
    @(negedge clk);
    // model of the edge just taken
    was_wait = m_wait;
    was_pend = m_pend;
    lau = !m_pend && !m_wait && !dr && !pu && (mq.size() < DEPTH);
    acc = m_pend && rdy;
    rsp = m_wait && rv;
    if (pu) mq.delete();
    else begin
      if (pop && mq.size() > 0) void'(mq.pop_front());
      if (rsp && !m_stale) mq.push_back(word_at(m_raddr));
    end
    if (pu) m_stale = m_pend | (m_wait & ~rsp);
    else if (rsp) m_stale = 1'b0;
    if (acc) begin m_wait = 1'b1; m_pend = 1'b0; m_raddr = m_addr; lat = $urandom % lat_max; end
    if (rsp) m_wait = 1'b0;
    if (pu) begin m_ptr = pa; m_new = 1'b1; end
    if (lau) begin
      m_pend = 1'b1; m_addr = m_ptr; m_code = m_new ? 4'b1001 : 4'b1000;
      m_ptr = m_ptr + ADDR_W'(2); m_new = 1'b0;
    end
    // compare
    if (was_wait)      check(fetch_valid_o == m_pend, "R11", 32'(fetch_valid_o), 32'(m_pend));
    else if (dr)       check(fetch_valid_o == m_pend, "R6", 32'(fetch_valid_o), 32'(m_pend));
    else               check(fetch_valid_o == m_pend, "R2", 32'(fetch_valid_o), 32'(m_pend));
    if (m_pend && fetch_valid_o) begin
      if (was_pend && !acc)
        check(fetch_addr_o == m_addr && bus_status_o == m_code, "R10", 32'(fetch_addr_o), 32'(m_addr));
      else if (m_code == 4'b1001) begin
        check(fetch_addr_o == m_addr, "R4", 32'(fetch_addr_o), 32'(m_addr));
        check(bus_status_o == 4'b1001, "R4", 32'(bus_status_o), 32'h9);
      end else begin
        check(fetch_addr_o == m_addr, "R3", 32'(fetch_addr_o), 32'(m_addr));
        check(bus_status_o == 4'b1000, "R3", 32'(bus_status_o), 32'h8);
      end
    end else if (!m_pend) begin
      check(bus_status_o == (dr ? 4'b1010 : 4'b0000), "R5", 32'(bus_status_o), dr ? 32'hA : 32'h0);
    end
    if (pu) check(q_valid_o == 1'b0, "R7", 32'(q_valid_o), 32'h0);
    else    check(q_valid_o == (mq.size() != 0), "R9", 32'(q_valid_o), 32'(mq.size() != 0));
    if (q_valid_o && mq.size() != 0)
      check(q_data_o == mq[0], "R9", 32'(q_data_o), 32'(mq[0]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(fetch_valid_o == 1'b0, "R1", 32'(fetch_valid_o), 32'h0);
    check(q_valid_o == 1'b0, "R1", 32'(q_valid_o), 32'h0);
    check(bus_status_o == 4'b0000, "R1", 32'(bus_status_o), 32'h0);
    rst_n = 1'b1;

    // R2: never-draining pop side, prefetch stops at DEPTH words
    p_ready = 100; p_pop = 0; lat_max = 2;
    repeat (40) step();
    check(mq.size() == DEPTH, "R2", 32'(mq.size()), 32'(DEPTH));
    check(fetch_valid_o == 1'b0, "R2", 32'(fetch_valid_o), 32'h0);

    // R6: long data request, with room in the store
    p_pop = 100; p_data = 100;
    repeat (10) step();
    p_pop = 0;
    repeat (10) step();
    check(fetch_valid_o == 1'b0, "R6", 32'(fetch_valid_o), 32'h0);
    p_data = 0;

    // R8: purge while a fetch awaits data
    p_purge = 100; fix_en = 1'b1; fix_addr = 24'h000200;
    step();
    p_purge = 0; lat_max = 6;
    for (int i = 0; i < 20 && !m_wait; i++) step();
    p_purge = 100; fix_addr = 24'h001000;
    step();
    p_purge = 0; fix_en = 1'b0;
    for (int i = 0; i < 40 && !q_valid_o; i++) step();
    check(q_data_o == word_at(24'h001000), "R8", 32'(q_data_o), 32'(word_at(24'h001000)));

    // random mix
    lat_max = 4;
    for (int i = 0; i < 3000; i++) begin
      p_purge = 4; p_data = 20; p_ready = 60; p_pop = 55;
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule